// File: doc/BRIEF.md
# I2C Controller Byte FIFO Pair with Self-Clearing Flush

This block holds the two byte queues that sit between a register-mapped host port and an I2C bus engine. Outgoing bytes enter the transmit queue through a host write strobe and leave it through a pop handshake from the engine. Incoming bytes enter the receive queue through a push handshake from the engine and leave it through a host read strobe. Both queues are 16 bytes deep by default.

Each queue has a programmable threshold register. The transmit side reports nearly-empty and the receive side reports nearly-full, next to the usual empty and full levels. A host write into a full transmit queue is dropped and sets a sticky overrun flag.

Each queue also has a flush request bit in the control word. Setting the bit starts a flush that lasts a fixed number of cycles. The bit reads back as 1 until the flush ends, and the hardware then clears it. While a queue is flushing it ignores every data access, so its state cannot be corrupted.

Top module: `i2c_fifo_pair`

## Requirements
- R1: After reset both queues are empty and not full. The overrun flag is 0, both flush bits read 0 and both thresholds are 0, so tx_near_empty and rx_near_full are both 1.
- R2: Bytes written with host_wr_en leave through eng_tx_pop in write order. eng_tx_data shows the oldest byte. tx_full is 1 exactly when 16 bytes are stored and tx_empty exactly when none are.
- R3: Bytes pushed with eng_rx_push leave through host_rd_en in push order. A read from an empty receive queue returns 0 and does not move the read pointer.
- R4: A host write while tx_full is 1 is dropped and leaves the stored bytes unchanged. It sets tx_ovr, which stays 1 until an ovr_clr pulse; if both happen in the same cycle, the set wins.
- R5: tx_near_empty is 1 exactly when the number of stored transmit bytes is less than or equal to the transmit threshold (0 to 15).
- R6: rx_near_full is 1 exactly when the number of stored receive bytes is greater than or equal to the receive threshold (0 to 15).
- R7: Control bit 7 (ctl_wdata[7]) starts a transmit flush and bit 8 (ctl_wdata[8]) starts a receive flush. The matching ctl_rdata bit reads 1 for exactly FLUSH_CYCLES cycles after the write, then clears by itself, and the queue is then empty. A request for a queue that is already flushing is ignored.
- R8: While a queue is flushing, host and engine data accesses to it are ignored. Its data output reads 0, its level flags hold still, and a write to a full transmit queue does not set tx_ovr.
- R9: A pop from an empty transmit queue is ignored and eng_tx_data reads 0. A push into a full receive queue is dropped.
- R10: A push and a pop on the same queue in the same cycle both take effect, and the stored count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe for transmit data |
| host_wr_data | input | 8 | Transmit byte from host |
| host_rd_en | input | 1 | Host read strobe for receive data |
| host_rd_data | output | 8 | Oldest receive byte; 0 when empty or flushing |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wdata | input | 2 (bits 8:7) | Bit 8 requests a receive flush, bit 7 a transmit flush |
| ctl_rdata | output | 2 (bits 8:7) | Flush in progress (bit 8 receive, bit 7 transmit) |
| tx_thr_we | input | 1 | Load the transmit threshold |
| rx_thr_we | input | 1 | Load the receive threshold |
| thr_wdata | input | 4 | Threshold value |
| ovr_clr | input | 1 | Clear the transmit overrun flag |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte; 0 when empty or flushing |
| eng_rx_push | input | 1 | Engine delivers a receive byte |
| eng_rx_data | input | 8 | Receive byte from the engine |
| tx_empty | output | 1 | Transmit queue empty |
| tx_near_empty | output | 1 | Transmit count at or below its threshold |
| tx_full | output | 1 | Transmit queue full |
| tx_ovr | output | 1 | Sticky transmit overrun |
| rx_empty | output | 1 | Receive queue empty |
| rx_near_full | output | 1 | Receive count at or above its threshold |
| rx_full | output | 1 | Receive queue full |

## Verification
The assertions check on every cycle that the level flags agree with one another, that overrun is set by a write into a full queue and then holds, and that data outputs read 0 when a queue is empty or flushing. They also check that flags do not move inside a flush, that a flush bit stays up no longer than FLUSH_CYCLES, and that a queue is empty when its flush bit falls. Only the bench scenarios can show byte ordering, the exact threshold crossing points, that dropped writes leave the contents intact, and that an ignored empty read leaves the pointer where it was.

// File: rtl/i2c_fifo_pair_pkg.sv
package i2c_fifo_pair_pkg;
   // Control word bit positions; software decodes these.
   localparam int unsigned FLUSH_TX_POS = 7;
   localparam int unsigned FLUSH_RX_POS = 8;

   typedef enum logic {
      NEAR_AT_OR_BELOW = 1'b0,
      NEAR_AT_OR_ABOVE = 1'b1
   } near_mode_e;
endpackage

// File: rtl/i2c_fifo_store.sv
module i2c_fifo_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic [DATA_W-1:0]            push_data,
   input  logic                         pop,
   output logic [DATA_W-1:0]            head,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH+1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr;
   logic [AW-1:0]     rptr;
   logic [CW-1:0]     cnt;
   logic              do_push;
   logic              do_pop;

   assign do_push = push && (cnt != CW'(DEPTH));
   assign do_pop  = pop  && (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (clr) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wptr] <= push_data;
   end

   assign head  = (cnt == '0) ? '0 : mem[rptr];
   assign count = cnt;
endmodule

// File: rtl/i2c_fifo_level.sv
module i2c_fifo_level
   import i2c_fifo_pair_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned THR_W = 4,
   parameter near_mode_e  MODE  = NEAR_AT_OR_BELOW
) (
   input  logic [$clog2(DEPTH+1)-1:0] count,
   input  logic [THR_W-1:0]           thr,
   output logic                       empty,
   output logic                       full,
   output logic                       near
);
   localparam int unsigned CW = $clog2(DEPTH+1);

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

   generate
      if (MODE == NEAR_AT_OR_BELOW) begin : g_below
         assign near = (count <= CW'(thr));
      end else begin : g_above
         assign near = (count >= CW'(thr));
      end
   endgenerate
endmodule

// File: rtl/i2c_flush_seq.sv
module i2c_flush_seq #(
   parameter int unsigned CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   logic [CW-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         left <= '0;
      end else if (busy) begin
         if (left == '0) busy <= 1'b0;
         else            left <= left - 1'b1;
      end else if (start) begin
         busy <= 1'b1;
         left <= CW'(CYCLES - 1);
      end
   end

   assign done = busy && (left == '0);
endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
   import i2c_fifo_pair_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned DEPTH        = 16,
   parameter int unsigned THR_W        = 4,
   parameter int unsigned FLUSH_CYCLES = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               host_wr_en,
   input  logic [DATA_W-1:0]                  host_wr_data,
   input  logic                               host_rd_en,
   output logic [DATA_W-1:0]                  host_rd_data,
   input  logic                               ctl_wr_en,
   input  logic [FLUSH_RX_POS:FLUSH_TX_POS]   ctl_wdata,
   output logic [FLUSH_RX_POS:FLUSH_TX_POS]   ctl_rdata,
   input  logic                               tx_thr_we,
   input  logic                               rx_thr_we,
   input  logic [THR_W-1:0]                   thr_wdata,
   input  logic                               ovr_clr,
   input  logic                               eng_tx_pop,
   output logic [DATA_W-1:0]                  eng_tx_data,
   input  logic                               eng_rx_push,
   input  logic [DATA_W-1:0]                  eng_rx_data,
   output logic                               tx_empty,
   output logic                               tx_near_empty,
   output logic                               tx_full,
   output logic                               tx_ovr,
   output logic                               rx_empty,
   output logic                               rx_near_full,
   output logic                               rx_full
);
   localparam int unsigned CW    = $clog2(DEPTH+1);
   localparam int unsigned N_CH  = 2;
   localparam int unsigned CH_TX = 0;
   localparam int unsigned CH_RX = 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if ((1 << THR_W) > DEPTH) begin : g_bad_thr
         $error("largest threshold must stay below DEPTH");
      end
      if (FLUSH_CYCLES < 1) begin : g_bad_flush
         $error("FLUSH_CYCLES must be at least 1");
      end
   endgenerate

   // ---------------- flush sequencers, one per queue ----------------
   logic [N_CH-1:0] fl_start;
   logic [N_CH-1:0] fl_busy;
   logic [N_CH-1:0] fl_done;

   assign fl_start[CH_TX] = ctl_wr_en && ctl_wdata[FLUSH_TX_POS];
   assign fl_start[CH_RX] = ctl_wr_en && ctl_wdata[FLUSH_RX_POS];

   genvar g;
   generate
      for (g = 0; g < N_CH; g++) begin : g_flush
         i2c_flush_seq #(.CYCLES(FLUSH_CYCLES)) i_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .start (fl_start[g]),
            .busy  (fl_busy[g]),
            .done  (fl_done[g])
         );
      end
   endgenerate

   assign ctl_rdata[FLUSH_TX_POS] = fl_busy[CH_TX];
   assign ctl_rdata[FLUSH_RX_POS] = fl_busy[CH_RX];

   // ---------------- threshold registers ----------------
   logic [THR_W-1:0] tx_thr_q;
   logic [THR_W-1:0] rx_thr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_thr_q <= '0;
         rx_thr_q <= '0;
      end else begin
         if (tx_thr_we) tx_thr_q <= thr_wdata;
         if (rx_thr_we) rx_thr_q <= thr_wdata;
      end
   end

   // ---------------- transmit queue ----------------
   logic [CW-1:0]     tx_cnt;
   logic [DATA_W-1:0] tx_head;
   logic              tx_wr_ok;
   logic              tx_wr_ovf;

   assign tx_wr_ok  = host_wr_en && !fl_busy[CH_TX] && !tx_full;
   assign tx_wr_ovf = host_wr_en && !fl_busy[CH_TX] &&  tx_full;

   i2c_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_tx_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (fl_done[CH_TX]),
      .push      (tx_wr_ok),
      .push_data (host_wr_data),
      .pop       (eng_tx_pop && !fl_busy[CH_TX]),
      .head      (tx_head),
      .count     (tx_cnt)
   );

   i2c_fifo_level #(.DEPTH(DEPTH), .THR_W(THR_W), .MODE(NEAR_AT_OR_BELOW)) i_tx_level (
      .count (tx_cnt),
      .thr   (tx_thr_q),
      .empty (tx_empty),
      .full  (tx_full),
      .near  (tx_near_empty)
   );

   assign eng_tx_data = fl_busy[CH_TX] ? '0 : tx_head;

   always_ff @(posedge clk) begin
      if (!rst_n)         tx_ovr <= 1'b0;
      else if (tx_wr_ovf) tx_ovr <= 1'b1;
      else if (ovr_clr)   tx_ovr <= 1'b0;
   end

   // ---------------- receive queue ----------------
   logic [CW-1:0]     rx_cnt;
   logic [DATA_W-1:0] rx_head;

   i2c_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (fl_done[CH_RX]),
      .push      (eng_rx_push && !fl_busy[CH_RX]),
      .push_data (eng_rx_data),
      .pop       (host_rd_en && !fl_busy[CH_RX]),
      .head      (rx_head),
      .count     (rx_cnt)
   );

   i2c_fifo_level #(.DEPTH(DEPTH), .THR_W(THR_W), .MODE(NEAR_AT_OR_ABOVE)) i_rx_level (
      .count (rx_cnt),
      .thr   (rx_thr_q),
      .empty (rx_empty),
      .full  (rx_full),
      .near  (rx_near_full)
   );

   assign host_rd_data = fl_busy[CH_RX] ? '0 : rx_head;
endmodule

// File: rtl/i2c_fifo_pair_chk.sv
module i2c_fifo_pair_chk #(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned FLUSH_CYCLES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr_en,
   input logic              ovr_clr,
   input logic [8:7]        ctl_rdata,
   input logic [DATA_W-1:0] host_rd_data,
   input logic [DATA_W-1:0] eng_tx_data,
   input logic              tx_empty,
   input logic              tx_near_empty,
   input logic              tx_full,
   input logic              tx_ovr,
   input logic              rx_empty,
   input logic              rx_near_full,
   input logic              rx_full
);
   localparam int unsigned LW = $clog2(FLUSH_CYCLES + 2);

   logic [LW-1:0] tx_len;
   logic [LW-1:0] rx_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_len <= '0;
         rx_len <= '0;
      end else begin
         tx_len <= !ctl_rdata[7] ? '0 : (tx_len == LW'(FLUSH_CYCLES) ? tx_len : tx_len + 1'b1);
         rx_len <= !ctl_rdata[8] ? '0 : (rx_len == LW'(FLUSH_CYCLES) ? rx_len : rx_len + 1'b1);
      end
   end

   p_level_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_empty && tx_full) && !(rx_empty && rx_full));

   p_empty_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |-> host_rd_data == '0);

   p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_en && tx_full && !ctl_rdata[7]) |=> tx_ovr);

   p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovr && !ovr_clr) |=> tx_ovr);

   p_near_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> tx_near_empty);

   p_near_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> rx_near_full);

   p_flush_len_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[7] |-> tx_len < LW'(FLUSH_CYCLES));

   p_flush_len_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[8] |-> rx_len < LW'(FLUSH_CYCLES));

   p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctl_rdata[7]) |-> tx_empty) and ($fell(ctl_rdata[8]) |-> rx_empty));

   p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[7] && $past(ctl_rdata[7])) |-> ($stable(tx_full) && $stable(tx_empty) && eng_tx_data == '0));

   p_flush_rx_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[8] && $past(ctl_rdata[8])) |-> ($stable(rx_full) && $stable(rx_empty) && host_rd_data == '0));

   p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> eng_tx_data == '0);
endmodule

bind i2c_fifo_pair i2c_fifo_pair_chk #(.DATA_W(DATA_W), .FLUSH_CYCLES(FLUSH_CYCLES)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_wr_en    (host_wr_en),
   .ovr_clr       (ovr_clr),
   .ctl_rdata     (ctl_rdata),
   .host_rd_data  (host_rd_data),
   .eng_tx_data   (eng_tx_data),
   .tx_empty      (tx_empty),
   .tx_near_empty (tx_near_empty),
   .tx_full       (tx_full),
   .tx_ovr        (tx_ovr),
   .rx_empty      (rx_empty),
   .rx_near_full  (rx_near_full),
   .rx_full       (rx_full)
);

// File: tb/test_i2c_fifo_pair.sv
module test_i2c_fifo_pair;
   localparam int CLK_PERIOD = 10;
   localparam int FLUSH      = 4;
   localparam int DEPTH      = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr_en = 0, host_rd_en = 0, ctl_wr_en = 0;
   logic [7:0] host_wr_data = 0, eng_rx_data = 0;
   logic [8:7] ctl_wdata = 0;
   logic       tx_thr_we = 0, rx_thr_we = 0, ovr_clr = 0;
   logic [3:0] thr_wdata = 0;
   logic       eng_tx_pop = 0, eng_rx_push = 0;
   logic [7:0] host_rd_data, eng_tx_data;
   logic [8:7] ctl_rdata;
   logic       tx_empty, tx_near_empty, tx_full, tx_ovr;
   logic       rx_empty, rx_near_full, rx_full;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_fifo_pair #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH)) i_i2c_fifo_pair (
      .clk(clk), .rst_n(rst_n),
      .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
      .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
      .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .tx_thr_we(tx_thr_we), .rx_thr_we(rx_thr_we), .thr_wdata(thr_wdata),
      .ovr_clr(ovr_clr),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .tx_empty(tx_empty), .tx_near_empty(tx_near_empty), .tx_full(tx_full), .tx_ovr(tx_ovr),
      .rx_empty(rx_empty), .rx_near_full(rx_near_full), .rx_full(rx_full)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tx_write(input logic [7:0] b);
      host_wr_data = b; host_wr_en = 1;
      @(negedge clk); host_wr_en = 0;
   endtask

   task automatic tx_pop_chk(input logic [7:0] exp, input string req);
      check(req, eng_tx_data, exp);
      eng_tx_pop = 1;
      @(negedge clk); eng_tx_pop = 0;
   endtask

   task automatic rx_push(input logic [7:0] b);
      eng_rx_data = b; eng_rx_push = 1;
      @(negedge clk); eng_rx_push = 0;
   endtask

   task automatic rx_read_chk(input logic [7:0] exp, input string req);
      check(req, host_rd_data, exp);
      host_rd_en = 1;
      @(negedge clk); host_rd_en = 0;
   endtask

   task automatic set_thr(input bit rx, input logic [3:0] v);
      thr_wdata = v; tx_thr_we = !rx; rx_thr_we = rx;
      @(negedge clk); tx_thr_we = 0; rx_thr_we = 0;
   endtask

   task automatic t_reset();
      check("R1 tx_empty", tx_empty, 1);
      check("R1 tx_full", tx_full, 0);
      check("R1 rx_empty", rx_empty, 1);
      check("R1 rx_full", rx_full, 0);
      check("R1 tx_ovr", tx_ovr, 0);
      check("R1 ctl_rdata", ctl_rdata, 0);
      check("R1 tx_near_empty", tx_near_empty, 1);
      check("R1 rx_near_full", rx_near_full, 1);
   endtask

   task automatic t_tx_order();
      for (int i = 0; i < 5; i++) tx_write(8'hA0 + 8'(i));
      check("R2 not empty", tx_empty, 0);
      for (int i = 0; i < 5; i++) tx_pop_chk(8'hA0 + 8'(i), "R2 order");
      check("R2 empty after drain", tx_empty, 1);
      tx_pop_chk(8'h00, "R9 pop empty reads 0");
      tx_write(8'h12);
      tx_pop_chk(8'h12, "R9 pointer kept after empty pop");
   endtask

   task automatic t_tx_full_ovr();
      for (int i = 0; i < DEPTH; i++) tx_write(8'h10 + 8'(i));
      check("R2 full at 16", tx_full, 1);
      check("R4 no overrun yet", tx_ovr, 0);
      tx_write(8'hEE);
      check("R4 overrun set", tx_ovr, 1);
      check("R4 still full", tx_full, 1);
      @(negedge clk);
      check("R4 overrun sticky", tx_ovr, 1);
      ovr_clr = 1; host_wr_data = 8'hEF; host_wr_en = 1;
      @(negedge clk); ovr_clr = 0; host_wr_en = 0;
      check("R4 set wins over clear", tx_ovr, 1);
      for (int i = 0; i < DEPTH; i++) tx_pop_chk(8'h10 + 8'(i), "R4 contents unchanged");
      ovr_clr = 1; @(negedge clk); ovr_clr = 0;
      check("R4 overrun cleared", tx_ovr, 0);
   endtask

   task automatic t_tx_thresh();
      set_thr(0, 4'd3);
      for (int k = 0; k <= 5; k++) begin
         check("R5 near_empty vs count", tx_near_empty, (k <= 3));
         tx_write(8'(k));
      end
      for (int k = 0; k <= 5; k++) tx_pop_chk(8'(k), "R5 drain");
      set_thr(0, 4'd0);
   endtask

   task automatic t_rx();
      rx_read_chk(8'h00, "R3 empty read 0");
      rx_push(8'h5A);
      rx_read_chk(8'h5A, "R3 pointer kept after empty read");
      set_thr(1, 4'd5);
      for (int k = 0; k <= 6; k++) begin
         check("R6 near_full vs count", rx_near_full, (k >= 5));
         rx_push(8'h20 + 8'(k));
      end
      for (int k = 7; k < DEPTH; k++) rx_push(8'h20 + 8'(k));
      check("R9 rx full", rx_full, 1);
      rx_push(8'hFF);
      for (int k = 0; k < DEPTH; k++) rx_read_chk(8'h20 + 8'(k), "R3 order / R9 drop");
      check("R3 rx empty", rx_empty, 1);
      set_thr(1, 4'd0);
   endtask

   task automatic t_flush_tx();
      int hi;
      for (int i = 0; i < DEPTH; i++) tx_write(8'h60 + 8'(i));
      ctl_wdata = 2'b01; ctl_wr_en = 1;
      @(negedge clk); ctl_wr_en = 0;
      hi = 0;
      for (int i = 0; i < 12; i++) begin
         if (ctl_rdata[7]) hi++;
         if (i == 1) begin
            check("R8 tx data 0 in flush", eng_tx_data, 0);
            check("R8 full held in flush", tx_full, 1);
            host_wr_data = 8'h99; host_wr_en = 1;
         end
         if (i == 2) begin
            eng_tx_pop = 1; ctl_wdata = 2'b01; ctl_wr_en = 1;
         end
         @(negedge clk);
         host_wr_en = 0; eng_tx_pop = 0; ctl_wr_en = 0;
      end
      check("R7 tx flush length", hi, FLUSH);
      check("R7 tx bit self-clears", ctl_rdata[7], 0);
      check("R7 tx empty after flush", tx_empty, 1);
      check("R8 no overrun in flush", tx_ovr, 0);
      tx_write(8'h77);
      tx_pop_chk(8'h77, "R7 usable after flush");
   endtask

   task automatic t_flush_both();
      for (int i = 0; i < 3; i++) rx_push(8'h80 + 8'(i));
      tx_write(8'h44);
      ctl_wdata = 2'b11; ctl_wr_en = 1;
      @(negedge clk); ctl_wr_en = 0;
      check("R7 both bits set", ctl_rdata, 2'b11);
      check("R8 rx read 0 in flush", host_rd_data, 0);
      host_rd_en = 1; eng_rx_push = 1; eng_rx_data = 8'hCC;
      @(negedge clk); host_rd_en = 0; eng_rx_push = 0;
      for (int i = 0; i < FLUSH - 1; i++) @(negedge clk);
      check("R7 both bits clear", ctl_rdata, 2'b00);
      check("R8 rx empty after flush", rx_empty, 1);
      check("R7 tx empty after flush", tx_empty, 1);
   endtask

   task automatic t_simul();
      tx_write(8'h31);
      tx_write(8'h32);
      check("R10 head before", eng_tx_data, 8'h31);
      host_wr_data = 8'h33; host_wr_en = 1; eng_tx_pop = 1;
      @(negedge clk); host_wr_en = 0; eng_tx_pop = 0;
      tx_pop_chk(8'h32, "R10 second");
      tx_pop_chk(8'h33, "R10 third");
      check("R10 empty", tx_empty, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_tx_order();
      t_tx_full_ovr();
      t_tx_thresh();
      t_rx();
      t_flush_tx();
      t_flush_both();
      t_simul();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule